// File: doc/BRIEF.md
# NAND Flash Host Sequencer

This block sits between a simple request port and an asynchronous byte-wide NAND flash device. The host asks for one of five operations: page read, page program, block erase, identifier read or status read. The block then produces every command, address and data cycle on the device pins.

Commands, addresses and data share one 8-bit bus. The block marks each bus cycle as a command cycle or an address cycle by raising the matching latch-enable line. Write-enable and read-enable pulses are timed in clock counts that can be changed while the block is idle. After a confirm command the block waits on the active-low ready/busy line. Once a program or erase has finished, it reads the status byte on its own and reports a failure.

Page data moves one byte at a time. Program data comes in through a valid/ready handshake. Read data goes out as a one-cycle valid pulse with the byte. A page holds 2112 bytes (2048 main plus 64 spare), so the column address is 12 bits. The row address is 16 bits: a 10-bit block index above a 6-bit page index.

Top module: `nand_host_seq`

## Requirements
- R1: A bus cycle is a command when the command latch is high, an address when the address latch is high, and data when both are low. Both latches are never high together.
- R2: Page read (op 0) sends command 00h. It then sends four address bytes in this order: column bits 7:0, column bits 11:8 (upper nibble zero), row bits 7:0, row bits 15:8. It then sends command 30h, waits for ready, and returns `reqLen` bytes (1 to 2112) in device order on `rdValid`/`rdData`.
- R3: Page program (op 1) sends command 80h and the same four address bytes. It then writes `reqLen` data bytes, each taken when `wrValid` and `wrReady` are both high, and sends command 10h.
- R4: Block erase (op 2) sends command 60h, then row bits 7:0 and row bits 15:8, then command D0h.
- R5: Identifier read (op 3) sends command 90h and one address byte 00h, then performs four read cycles. The first byte read lands in `idWord[7:0]` and the fourth in `idWord[31:24]`.
- R6: Status read (op 4) sends command 70h and performs one read cycle. The byte goes to `statusByte` and `fail` is 0.
- R7: After a program or erase has completed, the block sends 70h and reads one byte into `statusByte`. `fail` equals bit 0 of that byte.
- R8: While `nandRbN` is low, no write-enable or read-enable pulse occurs. The operation continues only after `nandRbN` returns high.
- R9: `nandWpN` is high only while a program or erase operation is in progress, and low at all other times.
- R10: `nandCeN` is low from the cycle after a request is accepted up to and including the `done` cycle, and high otherwise.
- R11: Before a command or address strobe falls, the latch enable is high for `cfgSetup` cycles. Every strobe stays low for `cfgLow` cycles. The timing values reset to 3, and a value of 0 acts as 1.
- R12: After reset, `nandCeN`, `nandWeN` and `nandReN` are high, `nandWpN` is low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Loads the three timing values |
| cfgSetup | input | 4 | Latch-enable setup, in clocks |
| cfgLow | input | 4 | Strobe low width, in clocks |
| cfgHigh | input | 4 | Strobe high width, in clocks |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request is taken |
| reqOp | input | 3 | 0 read, 1 program, 2 erase, 3 identifier, 4 status |
| reqCol | input | 12 | Column address |
| reqRow | input | 16 | Row address |
| reqLen | input | 12 | Data byte count for read and program |
| wrValid | input | 1 | Program byte present |
| wrReady | output | 1 | Program byte taken this cycle when valid |
| wrData | input | 8 | Program byte |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Program or erase failure |
| statusByte | output | 8 | Last status byte read |
| idWord | output | 32 | Four identifier bytes |
| nandCeN | output | 1 | Device chip enable, active low |
| nandCleO | output | 1 | Command latch enable |
| nandAleO | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandWpN | output | 1 | Write protect, active low |
| nandDqOut | output | 8 | Bus value driven to the device |
| nandDqOe | output | 1 | Bus output enable |
| nandDqIn | input | 8 | Bus value from the device |
| nandRbN | input | 1 | Ready/busy, low while busy |

## Verification
Four rules are checked on every cycle by assertions:
- the two latch enables are never high together;
- the two strobes never overlap;
- chip enable is low whenever either strobe is low;
- write protect matches the opcode being strobed, and the wait state holds while the synchronized busy line is low.

Some behaviour can only be shown by the bench scenarios against its device model:
- the exact order of command, address and data bytes for each operation;
- the packing of the identifier bytes;
- the status-bit failure report;
- the measured setup and low widths after the timing values are reprogrammed, including the zero case.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_ID     = 3'd3,
    OP_STATUS = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    CY_CMD   = 2'd0,
    CY_ADDR  = 2'd1,
    CY_WDATA = 2'd2,
    CY_RDATA = 2'd3
  } cyc_e;

  typedef struct packed {
    logic       go;
    cyc_e       kind;
    logic [7:0] data;
  } busCtl_t;

  localparam logic [7:0] OPC_READ1  = 8'h00;
  localparam logic [7:0] OPC_READ2  = 8'h30;
  localparam logic [7:0] OPC_PROG1  = 8'h80;
  localparam logic [7:0] OPC_PROG2  = 8'h10;
  localparam logic [7:0] OPC_ERASE1 = 8'h60;
  localparam logic [7:0] OPC_ERASE2 = 8'hD0;
  localparam logic [7:0] OPC_ID     = 8'h90;
  localparam logic [7:0] OPC_STAT   = 8'h70;

endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer
  import nand_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  busCtl_t       ctl,
  input  logic [TW-1:0] tSetup,
  input  logic [TW-1:0] tLow,
  input  logic [TW-1:0] tHigh,
  input  logic [7:0]    dqIn,
  output logic          idle,
  output logic          cycDone,
  output logic [7:0]    rdByte,
  output logic          cle,
  output logic          ale,
  output logic          weN,
  output logic          reN,
  output logic          dqOe,
  output logic [7:0]    dqOut
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_e;

  phase_e        phase;
  cyc_e          kind;
  logic [7:0]    byteQ;
  logic [TW-1:0] cnt;

  function automatic logic [TW-1:0] span(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      kind   <= CY_CMD;
      byteQ  <= '0;
      cnt    <= '0;
      rdByte <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (ctl.go) begin
          phase <= PH_SETUP;
          kind  <= ctl.kind;
          byteQ <= ctl.data;
          cnt   <= span(tSetup);
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_LOW;
          cnt   <= span(tLow);
        end else cnt <= cnt - 1'b1;
        PH_LOW: if (cnt == '0) begin
          phase <= PH_HIGH;
          cnt   <= span(tHigh);
          if (kind == CY_RDATA) rdByte <= dqIn;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign idle    = (phase == PH_IDLE);
  assign cycDone = (phase == PH_HIGH) && (cnt == '0);
  assign cle     = (phase != PH_IDLE) && (kind == CY_CMD);
  assign ale     = (phase != PH_IDLE) && (kind == CY_ADDR);
  assign weN     = !((phase == PH_LOW) && (kind != CY_RDATA));
  assign reN     = !((phase == PH_LOW) && (kind == CY_RDATA));
  assign dqOe    = (phase != PH_IDLE) && (kind != CY_RDATA);
  assign dqOut   = byteQ;

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int ROW_W      = 16,
  parameter int PAGE_BYTES = 2112,
  parameter int GUARD      = 4,
  localparam int LEN_W     = $clog2(PAGE_BYTES + 1),
  localparam int GW        = $clog2(GUARD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [COL_W-1:0] reqCol,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             done,
  output logic             fail,
  output logic [7:0]       statusByte,
  output logic [31:0]      idWord,
  input  logic             dpIdle,
  input  logic             dpDone,
  input  logic [7:0]       dpRdByte,
  input  logic             rbN,
  output busCtl_t          ctl,
  output logic             ceN,
  output logic             wpN
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT, S_RDATA, S_SCMD, S_SRD, S_DONE
  } st_e;

  st_e              state;
  op_e              opQ;
  logic [COL_W-1:0] colQ;
  logic [ROW_W-1:0] rowQ;
  logic [LEN_W-1:0] lenQ, xfer;
  logic [1:0]       aIdx;
  logic [GW-1:0]    waitCnt;
  logic             rbMeta, rbSync;
  logic             busState, lastAddr, lastXfer;
  logic [15:0]      colWide, rowWide;
  logic [1:0]       aSel;
  logic [7:0]       addrByte;

  assign colWide  = 16'(colQ);
  assign rowWide  = 16'(rowQ);
  assign busState = state inside {S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_RDATA, S_SCMD, S_SRD};
  assign lastXfer = (xfer == lenQ - 1'b1);
  assign aSel     = (opQ == OP_ERASE) ? aIdx + 2'd2 : aIdx;

  always_comb begin
    case (opQ)
      OP_ERASE: lastAddr = (aIdx == 2'd1);
      OP_ID:    lastAddr = 1'b1;
      default:  lastAddr = (aIdx == 2'd3);
    endcase
    case (aSel)
      2'd0:    addrByte = colWide[7:0];
      2'd1:    addrByte = colWide[15:8];
      2'd2:    addrByte = rowWide[7:0];
      default: addrByte = rowWide[15:8];
    endcase
    if (opQ == OP_ID) addrByte = 8'h00;
  end

  always_comb begin
    ctl.kind = CY_CMD;
    ctl.data = OPC_STAT;
    case (state)
      S_CMD1: case (opQ)
        OP_READ:  ctl.data = OPC_READ1;
        OP_PROG:  ctl.data = OPC_PROG1;
        OP_ERASE: ctl.data = OPC_ERASE1;
        OP_ID:    ctl.data = OPC_ID;
        default:  ctl.data = OPC_STAT;
      endcase
      S_CMD2: case (opQ)
        OP_READ:  ctl.data = OPC_READ2;
        OP_PROG:  ctl.data = OPC_PROG2;
        default:  ctl.data = OPC_ERASE2;
      endcase
      S_ADDR:  begin ctl.kind = CY_ADDR;  ctl.data = addrByte; end
      S_WDATA: begin ctl.kind = CY_WDATA; ctl.data = wrData;   end
      S_RDATA, S_SRD: begin ctl.kind = CY_RDATA; ctl.data = 8'h00; end
      default: ;
    endcase
    ctl.go = busState && dpIdle && ((state != S_WDATA) || wrValid);
  end

  assign reqReady = (state == S_IDLE);
  assign wrReady  = (state == S_WDATA) && dpIdle;
  assign done     = (state == S_DONE);
  assign ceN      = (state == S_IDLE);
  assign wpN      = (state != S_IDLE) && ((opQ == OP_PROG) || (opQ == OP_ERASE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbMeta <= 1'b1;
      rbSync <= 1'b1;
    end else begin
      rbMeta <= rbN;
      rbSync <= rbMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      opQ        <= OP_STATUS;
      colQ       <= '0;
      rowQ       <= '0;
      lenQ       <= '0;
      xfer       <= '0;
      aIdx       <= '0;
      waitCnt    <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
      fail       <= 1'b0;
      statusByte <= '0;
      idWord     <= '0;
    end else begin
      rdValid <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          state <= S_CMD1;
          opQ   <= op_e'(reqOp);
          colQ  <= reqCol;
          rowQ  <= reqRow;
          lenQ  <= (op_e'(reqOp) == OP_ID) ? LEN_W'(4) : reqLen;
          aIdx  <= '0;
          xfer  <= '0;
          fail  <= 1'b0;
        end
        S_CMD1: if (dpDone) state <= (opQ == OP_STATUS) ? S_SRD : S_ADDR;
        S_ADDR: if (dpDone) begin
          aIdx <= aIdx + 1'b1;
          if (lastAddr) begin
            xfer <= '0;
            case (opQ)
              OP_PROG: state <= S_WDATA;
              OP_ID:   state <= S_RDATA;
              default: state <= S_CMD2;
            endcase
          end
        end
        S_WDATA: if (dpDone) begin
          xfer <= xfer + 1'b1;
          if (lastXfer) state <= S_CMD2;
        end
        S_CMD2: if (dpDone) begin
          state   <= S_WAIT;
          waitCnt <= GW'(GUARD);
        end
        S_WAIT: if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
                else if (rbSync) begin
                  state <= (opQ == OP_READ) ? S_RDATA : S_SCMD;
                  xfer  <= '0;
                end
        S_RDATA: if (dpDone) begin
          xfer <= xfer + 1'b1;
          if (opQ == OP_READ) begin
            rdValid <= 1'b1;
            rdData  <= dpRdByte;
          end else idWord <= {dpRdByte, idWord[31:8]};
          if (lastXfer) state <= S_DONE;
        end
        S_SCMD: if (dpDone) state <= S_SRD;
        S_SRD: if (dpDone) begin
          statusByte <= dpRdByte;
          fail       <= ((opQ == OP_PROG) || (opQ == OP_ERASE)) && dpRdByte[0];
          state      <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !rbSync) |=> (state == S_WAIT)); // R8

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqOp == 3'd0 || reqOp == 3'd1))
      |-> (reqLen != '0 && int'(reqLen) <= PAGE_BYTES)); // R2

endmodule

// File: rtl/nand_host_seq.sv
module nand_host_seq
  import nand_seq_pkg::*;
#(
  parameter int TW         = 4,
  parameter int COL_W      = 12,
  parameter int ROW_W      = 16,
  parameter int PAGE_BYTES = 2112,
  parameter int GUARD      = 4,
  localparam int LEN_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [TW-1:0]    cfgSetup,
  input  logic [TW-1:0]    cfgLow,
  input  logic [TW-1:0]    cfgHigh,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [COL_W-1:0] reqCol,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             done,
  output logic             fail,
  output logic [7:0]       statusByte,
  output logic [31:0]      idWord,
  output logic             nandCeN,
  output logic             nandCleO,
  output logic             nandAleO,
  output logic             nandWeN,
  output logic             nandReN,
  output logic             nandWpN,
  output logic [7:0]       nandDqOut,
  output logic             nandDqOe,
  input  logic [7:0]       nandDqIn,
  input  logic             nandRbN
);

  logic [TW-1:0] tSetup, tLow, tHigh;
  busCtl_t       ctl;
  logic          dpIdle, dpDone;
  logic [7:0]    dpRdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tSetup <= TW'(3);
      tLow   <= TW'(3);
      tHigh  <= TW'(3);
    end else if (cfgWr) begin
      tSetup <= cfgSetup;
      tLow   <= cfgLow;
      tHigh  <= cfgHigh;
    end
  end

  nand_seq_ctrl #(
    .COL_W(COL_W), .ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES), .GUARD(GUARD)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqCol(reqCol), .reqRow(reqRow), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .done(done), .fail(fail),
    .statusByte(statusByte), .idWord(idWord),
    .dpIdle(dpIdle), .dpDone(dpDone), .dpRdByte(dpRdByte),
    .rbN(nandRbN), .ctl(ctl), .ceN(nandCeN), .wpN(nandWpN)
  );

  nand_seq_timer #(.TW(TW)) uTimer (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .tSetup(tSetup), .tLow(tLow), .tHigh(tHigh), .dqIn(nandDqIn),
    .idle(dpIdle), .cycDone(dpDone), .rdByte(dpRdByte),
    .cle(nandCleO), .ale(nandAleO), .weN(nandWeN), .reN(nandReN),
    .dqOe(nandDqOe), .dqOut(nandDqOut)
  );

  AST_ONE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCleO && nandAleO)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R1

  AST_CE_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN); // R10

  AST_WP_OPEN_MODIFY: assert property (@(posedge clk) disable iff (!rstN)
    (nandCleO && !nandWeN && (nandDqOut == OPC_PROG1 || nandDqOut == OPC_ERASE1))
      |-> nandWpN); // R9

  AST_WP_SHUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    (nandCleO && !nandWeN && (nandDqOut == OPC_READ1 || nandDqOut == OPC_ID))
      |-> !nandWpN); // R9

endmodule

// File: tb/tb_nand_host_seq.sv
module tb_nand_host_seq;

  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [3:0]  cfgSetup = '0, cfgLow = '0, cfgHigh = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqOp = '0;
  logic [11:0] reqCol = '0;
  logic [15:0] reqRow = '0;
  logic [11:0] reqLen = '0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [7:0]  wrData = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        done, fail;
  logic [7:0]  statusByte;
  logic [31:0] idWord;
  logic        nandCeN, nandCleO, nandAleO, nandWeN, nandReN, nandWpN, nandDqOe;
  logic [7:0]  nandDqOut;
  logic [7:0]  nandDqIn = '0;
  logic        nandRbN = 1'b1;

  always #5 clk = ~clk;

  nand_host_seq dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgSetup(cfgSetup), .cfgLow(cfgLow),
    .cfgHigh(cfgHigh), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqCol(reqCol), .reqRow(reqRow), .reqLen(reqLen), .wrValid(wrValid),
    .wrReady(wrReady), .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .done(done), .fail(fail), .statusByte(statusByte), .idWord(idWord),
    .nandCeN(nandCeN), .nandCleO(nandCleO), .nandAleO(nandAleO), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandWpN(nandWpN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe),
    .nandDqIn(nandDqIn), .nandRbN(nandRbN)
  );

  int checks = 0, errors = 0;
  int evQ[$], expQ[$], rdQ[$];
  int expSetup = 3, expLow = 3;
  int setupCnt = 0, lowCnt = 0, busyCnt = 0, pageIdx = 0, idIdx = 0;
  logic [7:0] lastCmd = '0, statusResp = 8'hE0;
  logic prevWe = 1'b1, prevRe = 1'b1;
  bit active = 0, modOp = 0;
  logic [7:0] idBytes [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pageByte(input int k);
    return 8'((k * 13 + 8'h5A) & 8'hFF);
  endfunction

  // request tracking from the host side
  always @(posedge clk) begin
    if (!rstN) active <= 0;
    else if (reqValid && reqReady) begin
      active <= 1;
      modOp  <= (reqOp == 3'd1 || reqOp == 3'd2);
    end else if (done) active <= 0;
  end

  // device model and per-cycle rules
  always @(negedge clk) if (rstN) begin
    chk(nandCeN == !active, "R10 chip enable", int'(nandCeN), int'(!active));
    chk(nandWpN == (active && modOp), "R9 write protect", int'(nandWpN), int'(active && modOp));
    chk(!(nandCleO && nandAleO), "R1 latches", int'({nandCleO, nandAleO}), 0);
    if (!nandRbN) chk(nandWeN && nandReN, "R8 strobe while busy", int'({nandWeN, nandReN}), 3);

    if (prevWe && !nandWeN && (nandCleO || nandAleO))
      chk(setupCnt == expSetup, "R11 setup", setupCnt, expSetup);
    if ((nandCleO || nandAleO) && nandWeN) setupCnt++; else setupCnt = 0;

    if (!nandWeN || !nandReN) lowCnt++;
    else if (lowCnt != 0) begin
      chk(lowCnt == expLow, "R11 low width", lowCnt, expLow);
      lowCnt = 0;
    end

    if (!prevWe && nandWeN) begin
      evQ.push_back((nandCleO ? 'h100 : 0) | (nandAleO ? 'h200 : 0) | int'(nandDqOut));
      if (nandCleO) begin
        lastCmd = nandDqOut;
        if (nandDqOut == 8'h90) idIdx = 0;
        if (nandDqOut == 8'h30) pageIdx = 0;
        if (nandDqOut == 8'h30 || nandDqOut == 8'h10 || nandDqOut == 8'hD0) busyCnt = BUSY;
      end
    end
    if (prevRe && !nandReN) begin
      case (lastCmd)
        8'h90:   begin nandDqIn = idBytes[idIdx % 4]; idIdx++; end
        8'h30:   begin nandDqIn = pageByte(pageIdx); pageIdx++; end
        default: nandDqIn = statusResp;
      endcase
    end
    if (busyCnt > 0) busyCnt--;
    nandRbN = (busyCnt == 0);
    if (rdValid) rdQ.push_back(int'(rdData));
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  task automatic runOp(input int op, input int col, input int row, input int len);
    @(negedge clk);
    reqValid = 1; reqOp = 3'(op); reqCol = 12'(col); reqRow = 16'(row); reqLen = 12'(len);
    @(negedge clk);
    reqValid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic feed(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wrValid = 1; wrData = 8'(base + i * 17);
      @(negedge clk);
      while (!wrReady) @(negedge clk);
      @(negedge clk);
    end
    wrValid = 0;
  endtask

  task automatic cmpEvents(input string req);
    chk(evQ.size() == expQ.size(), {req, " cycle count"}, evQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < evQ.size(); i++)
      chk(evQ[i] == expQ[i], {req, " bus cycle"}, evQ[i], expQ[i]);
    evQ.delete(); expQ.delete();
  endtask

  task automatic pushAddr4(input int col, input int row);
    expQ.push_back('h200 | (col & 'hFF));
    expQ.push_back('h200 | ((col >> 8) & 'hF));
    expQ.push_back('h200 | (row & 'hFF));
    expQ.push_back('h200 | ((row >> 8) & 'hFF));
  endtask

  task automatic setCfg(input int s, input int l, input int h);
    @(negedge clk);
    cfgWr = 1; cfgSetup = 4'(s); cfgLow = 4'(l); cfgHigh = 4'(h);
    @(negedge clk);
    cfgWr = 0;
    expSetup = (s == 0) ? 1 : s;
    expLow   = (l == 0) ? 1 : l;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nandCeN && nandWeN && nandReN, "R12 strobes idle", int'({nandCeN, nandWeN, nandReN}), 7);
    chk(!nandWpN, "R12 protect", int'(nandWpN), 0);
    chk(reqReady, "R12 ready", int'(reqReady), 1);
    rstN = 1;

    // R5 identifier read
    runOp(3, 0, 0, 0);
    expQ.push_back('h190); expQ.push_back('h200);
    cmpEvents("R5");
    chk(idWord == 32'hD4C3B2A1, "R5 id word", idWord, 32'hD4C3B2A1);

    // R6 status read
    statusResp = 8'hC1;
    runOp(4, 0, 0, 0);
    expQ.push_back('h170);
    cmpEvents("R6");
    chk(statusByte == 8'hC1, "R6 status", statusByte, 8'hC1);
    chk(!fail, "R6 no fail", fail, 0);

    // R2 page read at the last column
    runOp(0, 2111, 'hABCD, 5);
    expQ.push_back('h100); pushAddr4(2111, 'hABCD); expQ.push_back('h130);
    cmpEvents("R2");
    chk(rdQ.size() == 5, "R2 byte count", rdQ.size(), 5);
    for (int i = 0; i < rdQ.size(); i++)
      chk(rdQ[i] == int'(pageByte(i)), "R2 read byte", rdQ[i], int'(pageByte(i)));
    rdQ.delete();

    // R2 full page
    runOp(0, 0, 'h0040, 2112);
    expQ.push_back('h100); pushAddr4(0, 'h0040); expQ.push_back('h130);
    cmpEvents("R2 full");
    chk(rdQ.size() == 2112, "R2 full count", rdQ.size(), 2112);
    if (rdQ.size() == 2112)
      chk(rdQ[2111] == int'(pageByte(2111)), "R2 last byte", rdQ[2111], int'(pageByte(2111)));
    rdQ.delete();

    // R3 R7 program pass
    statusResp = 8'hE0;
    fork
      runOp(1, 5, 'h0102, 3);
      feed(3, 'h11);
    join
    expQ.push_back('h180); pushAddr4(5, 'h0102);
    for (int i = 0; i < 3; i++) expQ.push_back(('h11 + i * 17) & 'hFF);
    expQ.push_back('h110); expQ.push_back('h170);
    cmpEvents("R3");
    chk(!fail, "R7 program pass", fail, 0);
    chk(statusByte == 8'hE0, "R7 status", statusByte, 8'hE0);

    // R7 program fail
    statusResp = 8'hE1;
    fork
      runOp(1, 0, 0, 1);
      feed(1, 'h5C);
    join
    evQ.delete();
    chk(fail, "R7 program fail", fail, 1);

    // R4 erase pass and fail
    statusResp = 8'hE0;
    runOp(2, 'hFFF, 'h1234, 0);
    expQ.push_back('h160); expQ.push_back('h234); expQ.push_back('h212);
    expQ.push_back('h1D0); expQ.push_back('h170);
    cmpEvents("R4");
    chk(!fail, "R4 erase pass", fail, 0);
    statusResp = 8'h01;
    runOp(2, 0, 'h0001, 0);
    evQ.delete();
    chk(fail, "R7 erase fail", fail, 1);

    // R11 reprogrammed timing and zero values
    setCfg(1, 5, 2);
    runOp(3, 0, 0, 0);
    expQ.push_back('h190); expQ.push_back('h200);
    cmpEvents("R11 timing");
    setCfg(0, 0, 0);
    statusResp = 8'h80;
    runOp(4, 0, 0, 0);
    expQ.push_back('h170);
    cmpEvents("R11 zero");
    chk(statusByte == 8'h80, "R11 zero status", statusByte, 8'h80);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule